// File: doc/BRIEF.md
# Serial DAC Word Writer

This block hands one 12-bit conversion code to a serial digital-to-analog converter. A producer presents the code together with a 2-bit configuration field on a valid/ready handshake. On acceptance the block latches both values and assembles a 16-bit frame. It then drives three lines towards the converter: a frame-sync strobe, a serial clock and a serial data line.

The frame-sync line rests high. After acceptance it stays high for one full serial clock period, then drops and stays low while the 16 bits are clocked out, most significant bit first. The bit order is two forced zeros, the configuration field (high bit first), then the 12 code bits from bit 11 down to bit 0. New data appears with each rising serial clock edge and is steady at the following falling edge, where the converter samples it. The serial clock period is a whole number of system clocks, set by a parameter. When the last bit has been sampled, frame-sync returns high and the block is ready for the next word.

Top module: `sdac_word_writer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fsync_o` is 1, `sclk_o` is 0, `sdo_o` is 0 and `ready_o` is 1. A reset in the middle of a frame drops that frame.
- R2: A word is accepted only at a clock edge where `valid_i` and `ready_o` are both 1. `ready_o` is 0 from the cycle after that edge until the frame ends.
- R3: After acceptance, `fsync_o` stays 1 for exactly 2*DIV_HALF system clocks. It then falls to 0, together with the first rising edge of `sclk_o`.
- R4: The bits sampled on the falling edges of `sclk_o` while `fsync_o` is 0 are, in time order, 0, 0, cfg[1], cfg[0], data[11] down to data[0]. The word with the first bit in bit 15 equals {2'b00, cfg, data}.
- R5: `sdo_o` changes only in a cycle where `sclk_o` has just risen, or where `fsync_o` has just risen. At frame end it returns to 0.
- R6: Each high phase and each low phase of `sclk_o` lasts exactly DIV_HALF system clocks. `sclk_o` is 0 whenever `fsync_o` is 1.
- R7: While `fsync_o` is 0, `sclk_o` has exactly 16 rising edges, and `fsync_o` stays 0 for 32*DIV_HALF system clocks.
- R8: `ready_o` and `fsync_o` return to 1 in the same cycle at the end of a frame. `ready_o` is never 1 while `fsync_o` is 0.
- R9: Data and configuration are captured at acceptance. Changes on `data_i`, `cfg_i` or `valid_i` while `ready_o` is 0 do not affect the frame on the serial lines and start no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Producer offers a word |
| data_i | input | 12 | Code to be converted |
| cfg_i | input | 2 | Configuration field sent ahead of the code |
| ready_o | output | 1 | Block can accept a word |
| fsync_o | output | 1 | Frame-sync strobe, low during the 16 bits |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data, most significant bit first |

## Verification
The hardest case to reach from the ports is a second acceptance in the very cycle after `ready_o` returns high. Here the sequencer goes straight from the end of one frame into the lead phase of the next, and its divide counter must restart cleanly. The stimulus reaches this case by holding `valid_i` high across a whole frame while it changes `data_i` and `cfg_i` during the busy time. A second rare case is a reset that arrives partway through the shifted bits. The stimulus asserts `rst_n` low some dozens of cycles into a frame and checks that the serial lines return to idle and that no partial word is reported.

// File: rtl/sdac_pkg.sv
// Package: shared types and constants of the serial DAC word writer.
// Assumes: a frame is leading zero pad bits, then configuration, then data.
package sdac_pkg;

    // Sequencer states: idle, frame-sync lead period, bit shifting.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } sdac_state_e;

    // Number of forced zero bits at the head of each frame.
    localparam int PAD_W = 2;

endpackage

// File: rtl/sdac_half_timer.sv
// Module: sdac_half_timer
// Counts system clocks while run is high and pulses tick on the last clock
// of each serial half period. Assumes HALF >= 1. The counter restarts from
// zero whenever run is low, so the first half period after run rises is full.
module sdac_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    // Purpose: advance the half-period counter, wrapping at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdac_shifter.sv
// Module: sdac_shifter
// Holds the assembled frame and drives the registered serial data bit.
// Assumes load, advance and clear never coincide. Advance moves the next
// bit onto sdo; clear returns sdo to zero at the end of a frame.
module sdac_shifter #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] frame_in,
    input  logic          advance,
    input  logic          clear,
    output logic          sdo
);
    logic [FW-1:0] sreg_q;

    // Purpose: capture the frame at acceptance and shift it out MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            sdo    <= 1'b0;
        end else if (load) begin
            sreg_q <= frame_in;
        end else if (advance) begin
            sdo    <= sreg_q[FW-1];
            sreg_q <= {sreg_q[FW-2:0], 1'b0};
        end else if (clear) begin
            sdo    <= 1'b0;
        end
    end
endmodule

// File: rtl/sdac_ctrl.sv
// Module: sdac_ctrl
// Frame sequencer. It accepts a word on valid/ready, holds frame-sync high
// for one serial period, then lowers it and toggles the serial clock for FW
// bits. A bit starts on each rising serial clock edge. At the end it raises
// frame-sync and ready together. Assumes a half-period tick from the timer.
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int FW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic tick,
    output logic ready_o,
    output logic fsync_o,
    output logic sclk_o,
    output logic run_o,
    output logic load_o,
    output logic advance_o,
    output logic clear_o
);
    localparam int BW = $clog2(FW);
    localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

    sdac_state_e   state_q;
    logic          phase_q;
    logic [BW-1:0] bit_q;
    logic          accept;
    logic          lead_done;
    logic          bit_end;
    logic          last_bit;

    assign accept    = valid_i && ready_o && (state_q == ST_IDLE);
    assign lead_done = (state_q == ST_LEAD) && tick && phase_q;
    assign bit_end   = (state_q == ST_SHIFT) && tick && !sclk_o;
    assign last_bit  = (bit_q == LAST_BIT);

    assign run_o     = (state_q != ST_IDLE);
    assign load_o    = accept;
    assign advance_o = lead_done || (bit_end && !last_bit);
    assign clear_o   = bit_end && last_bit;

    // Purpose: step the frame sequence and drive the registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_o <= 1'b1;
            fsync_o <= 1'b1;
            sclk_o  <= 1'b0;
            phase_q <= 1'b0;
            bit_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_LEAD;
                        ready_o <= 1'b0;
                        phase_q <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (phase_q) begin
                            state_q <= ST_SHIFT;
                            fsync_o <= 1'b0;
                            sclk_o  <= 1'b1;
                            bit_q   <= '0;
                            phase_q <= 1'b0;
                        end else begin
                            phase_q <= 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (sclk_o) begin
                            sclk_o <= 1'b0;
                        end else if (last_bit) begin
                            state_q <= ST_IDLE;
                            fsync_o <= 1'b1;
                            ready_o <= 1'b1;
                        end else begin
                            bit_q  <= bit_q + 1'b1;
                            sclk_o <= 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    ready_o <= 1'b1;
                    fsync_o <= 1'b1;
                    sclk_o  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sdac_word_writer.sv
// Module: sdac_word_writer (top)
// Accepts a code and configuration field and writes them to a serial DAC
// as one frame: zero pad bits, configuration, code, MSB first, framed by
// an active-low sync strobe. DIV_HALF sets the system clocks per serial
// clock half period. Assumes DIV_HALF >= 1.
module sdac_word_writer
    import sdac_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int CFG_W    = 2,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              ready_o,
    output logic              fsync_o,
    output logic              sclk_o,
    output logic              sdo_o
);
    localparam int FW = PAD_W + CFG_W + DATA_W;

    logic          run;
    logic          tick;
    logic          load;
    logic          advance;
    logic          clear;
    logic [FW-1:0] frame_word;

    assign frame_word = {{PAD_W{1'b0}}, cfg_i, data_i};

    sdac_half_timer #(.HALF(DIV_HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    sdac_ctrl #(.FW(FW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .tick      (tick),
        .ready_o   (ready_o),
        .fsync_o   (fsync_o),
        .sclk_o    (sclk_o),
        .run_o     (run),
        .load_o    (load),
        .advance_o (advance),
        .clear_o   (clear)
    );

    sdac_shifter #(.FW(FW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .frame_in (frame_word),
        .advance  (advance),
        .clear    (clear),
        .sdo      (sdo_o)
    );
endmodule

// File: rtl/sdac_word_writer_chk.sv
// Module: sdac_word_writer_chk
// Protocol checker bound to the top. It watches only the port-level lines
// and counts serial clock phases and edges with its own registers.
module sdac_word_writer_chk #(
    parameter int DIV_HALF = 2,
    parameter int FW       = 16
) (
    input logic clk,
    input logic rst_n,
    input logic valid_i,
    input logic ready_o,
    input logic fsync_o,
    input logic sclk_o,
    input logic sdo_o
);
    int   hi_len;
    int   lo_len;
    int   rises;
    logic sclk_d;

    // Purpose: measure serial clock phase lengths and count rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= 0;
            lo_len <= 0;
            rises  <= 0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_o;
            hi_len <= sclk_o ? hi_len + 1 : 0;
            lo_len <= (!sclk_o && !fsync_o) ? lo_len + 1 : 0;
            rises  <= fsync_o ? 0 : rises + ((sclk_o && !sclk_d) ? 1 : 0);
        end
    end

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> !ready_o);

    assert_sdo_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> ($rose(sclk_o) || $rose(fsync_o)));

    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |-> !sclk_o);

    assert_high_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_len == DIV_HALF));

    assert_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && $past(!fsync_o)) |-> (lo_len == DIV_HALF));

    assert_edge_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_o) |-> (rises == FW));

    assert_ready_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> fsync_o);

    assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $rose(fsync_o));
endmodule

bind sdac_word_writer sdac_word_writer_chk #(
    .DIV_HALF (DIV_HALF),
    .FW       (PAD_W + CFG_W + DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .fsync_o (fsync_o),
    .sclk_o  (sclk_o),
    .sdo_o   (sdo_o)
);

// File: tb/test_sdac_word_writer.sv
`timescale 1ns/1ps
module test_sdac_word_writer;
    localparam int HALF = 3;
    localparam int P    = 2 * HALF;
    localparam int FW   = 16;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [11:0] data  = '0;
    logic [1:0]  cfg   = '0;
    logic        ready, fsync, sclk, sdo;

    sdac_word_writer #(.DATA_W(12), .CFG_W(2), .DIV_HALF(HALF)) i_sdac_word_writer (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .data_i(data), .cfg_i(cfg),
        .ready_o(ready), .fsync_o(fsync), .sclk_o(sclk), .sdo_o(sdo)
    );

    always #2 clk = ~clk;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    task automatic chk(input string req, input string nm, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Behavioural reference: t counts cycles since acceptance, -1 when idle.
    int          t = -1;
    logic [15:0] mfr = '0;
    logic [15:0] expq[$];
    int          completed = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            t = -1;
            expq.delete();
        end else if (t < 0) begin
            if (valid) begin
                t   = 0;
                mfr = {2'b00, cfg, data};
                expq.push_back(mfr);
            end
        end else begin
            t++;
            if (t == 17 * P) begin
                t = -1;
                completed++;
            end
        end
    end

    // Compare every output each cycle against the reference.
    always @(negedge clk) begin
        logic er, ef, ec, ed;
        if (t < 0) begin
            er = 1; ef = 1; ec = 0; ed = 0;
        end else if (t < P) begin
            er = 0; ef = 1; ec = 0; ed = 0;
        end else begin
            er = 0; ef = 0;
            ec = (((t - P) % P) < HALF);
            ed = mfr[15 - (t - P) / P];
        end
        if (!done) begin
            chk("R2_R8", "ready", ready, er);
            chk("R3_R7", "fsync", fsync, ef);
            chk("R6", "sclk", sclk, ec);
            chk("R4_R5", "sdo", sdo, ed);
        end
    end

    // Converter-side decoder: sample sdo on falling sclk while fsync is low.
    logic        p_sclk = 1'b0, p_fs = 1'b1;
    logic [15:0] dw = '0;
    int          dn = 0;
    int          decoded = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            dn = 0;
        end else begin
            if (!fsync && p_sclk && !sclk) begin
                dw = {dw[14:0], sdo};
                dn++;
            end
            if (fsync && !p_fs) begin
                chk("R7", "bits_in_frame", dn, FW);
                if (expq.size() > 0) begin
                    chk("R4_R9", "frame_word", dw, expq.pop_front());
                end else begin
                    chk("R9", "unexpected_frame", 1, 0);
                end
                decoded++;
                dn = 0;
            end
        end
        p_sclk = sclk;
        p_fs   = fsync;
    end

    task automatic send(input logic [11:0] d, input logic [1:0] c);
        @(negedge clk);
        data  = d;
        cfg   = c;
        valid = 1'b1;
        while (!ready) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
        data  = ~d;
        cfg   = ~c;
    endtask

    task automatic idle_check();
        chk("R1", "ready_idle", ready, 1);
        chk("R1", "fsync_idle", fsync, 1);
        chk("R1", "sclk_idle", sclk, 0);
        chk("R1", "sdo_idle", sdo, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check();
        rst_n = 1'b1;
        @(negedge clk);
        idle_check();

        send(12'h000, 2'b00);
        send(12'hFFF, 2'b11);
        send(12'hA5A, 2'b01);
        send(12'h801, 2'b10);

        // Back-to-back: valid held high; inputs change while busy (R9).
        @(negedge clk);
        data = 12'h3C7; cfg = 2'b10; valid = 1'b1;
        while (ready) @(negedge clk);
        data = 12'h5E1; cfg = 2'b01;
        repeat (20) @(negedge clk);
        data = 12'h0F0; cfg = 2'b11;
        while (!ready) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
        data  = 12'hFFF;

        // Valid pulses during a frame must be ignored (R9).
        send(12'h123, 2'b10);
        for (int k = 0; k < 6; k++) begin
            repeat (7) @(negedge clk);
            valid = ~valid;
            data  = data + 12'h111;
            cfg   = cfg + 2'b01;
        end
        valid = 1'b0;

        for (int k = 0; k < 4; k++) begin
            send(12'(k * 1237 + 91), 2'(k));
        end

        // Reset partway through the shifted bits (R1).
        send(12'hBEE, 2'b11);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        idle_check();
        rst_n = 1'b1;
        @(negedge clk);
        idle_check();
        send(12'h7A3, 2'b01);

        repeat (17 * P + 6) @(negedge clk);
        idle_check();
        chk("R9", "frames_decoded", decoded, completed);
        finish_run();
    end

    initial begin
        #(4 * 100000);
        mismatched++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end
endmodule